// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block accepts a batch of sixteen lane memory requests in one handshake. Each lane carries an enable bit and the byte address of a 32-bit word. The block turns the batch into the smallest set of aligned memory transactions that covers every enabled lane. Each transaction carries a segment base address, a size code for 32, 64 or 128 bytes, and a lane mask that names the lanes it serves.

Grouping works on 128-byte aligned blocks. In each cycle the block takes the lowest block that still has unserved lanes, collects all pending lanes in that block, and trims the segment. A 128-byte segment becomes 64 bytes, and a 64-byte segment becomes 32 bytes, when every collected lane lies in one aligned half of it. Transactions leave one per cycle through a valid/ready handshake. A one-cycle done pulse marks the end of each batch.

Top module: `coal_half_warp`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `batch_done` are 0.
- R2: Every issued `out_base` is aligned to the issued segment size.
- R3: `out_size` encodes 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. Every lane in `out_mask` has its address inside [`out_base`, `out_base` + size).
- R4: Each segment has the smallest aligned size (32, 64 or 128) that holds all of its lanes. Lanes that share one word, or that fit in 32 bytes, give a 32-byte transaction.
- R5: Lanes whose `in_lane_valid` bit is 0 never appear in any `out_mask`, and their addresses have no effect on the transactions.
- R6: Within a batch, transactions are issued in strictly ascending order of `out_base`.
- R7: If every enabled lane lies in one aligned 128-byte block, exactly one transaction is issued, whatever the order of lanes to addresses.
- R8: Sequential lanes with a word stride of 2 from a 128-byte aligned start give one 128-byte transaction. With a word stride of 3 they give a 128-byte transaction at the start and then a 64-byte transaction at start+128.
- R9: Each transaction's mask holds every still-pending enabled lane inside its segment. The masks of a batch are disjoint and together equal `in_lane_valid`.
- R10: A batch with no enabled lane issues no transaction. `batch_done` is 1 in the cycle after that batch is accepted.
- R11: `in_ready` is 0 while transactions of a batch remain. `batch_done` is 1 for the single cycle after the last transaction handshake, with `out_valid` 0.
- R12: While `out_valid` is 1 and `out_ready` is 0, the base, size and mask hold steady.
- R13: Sixteen lanes in sixteen different 128-byte blocks give sixteen transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Batch offered |
| in_ready | output | 1 | Batch can be accepted |
| in_lane_valid | input | LANES | Per-lane enable |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | Transaction available |
| out_ready | input | 1 | Transaction taken |
| out_base | output | ADDR_W | Segment base byte address |
| out_size | output | 2 | Size code: 0=32, 1=64, 2=128 bytes |
| out_mask | output | LANES | Lanes served by this transaction |
| batch_done | output | 1 | One-cycle pulse at batch end |

## Verification
The bench builds the block with its default values: sixteen lanes, 32-bit addresses, and segments from 32 to 128 bytes. These values bring in reach every trim level, the full sixteen-transaction worst case, and the stride-2 and stride-3 patterns at real half-warp width. Random back-pressure on `out_ready` exercises the holding of a stalled transaction. Random batches in a 2 KiB window mix partial lane masks, shared words and patterns that span several blocks.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } coal_state_e;

endpackage

// File: rtl/coal_rst_sync.sv
module coal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/coal_min_select.sv
// Picks the lowest largest-segment block among pending lanes and marks every
// pending lane that falls inside it.
module coal_min_select #(
  parameter int LANES = 16,
  parameter int KW    = 27,  // stored address bits per lane
  parameter int SPAN  = 2,   // trim bits below the block index
  localparam int BW   = KW - SPAN
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*KW-1:0] fields,
  output logic [BW-1:0]       best_blk,
  output logic [LANES-1:0]    sel_mask
);
  logic [BW-1:0] blk [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_blk
    assign blk[g] = fields[g*KW+SPAN +: BW];
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    best_blk = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!found || blk[i] < best_blk)) begin
        best_blk = blk[i];
        found    = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++) begin
      sel_mask[i] = pend[i] && (blk[i] == best_blk);
    end
  end
endmodule

// File: rtl/coal_trim.sv
// Shrinks a selected block to the smallest aligned segment holding its lanes.
module coal_trim #(
  parameter int LANES  = 16,
  parameter int KW     = 27,
  parameter int SPAN   = 2,
  parameter int MIN_LG = 5,
  parameter int SZ_W   = 2,
  localparam int BW    = KW - SPAN
) (
  input  logic [LANES-1:0]        sel_mask,
  input  logic [LANES*KW-1:0]     fields,
  input  logic [BW-1:0]           blk,
  output logic [BW+SPAN+MIN_LG-1:0] base,
  output logic [SZ_W-1:0]         size_code
);
  logic [SPAN-1:0] off [LANES];
  logic [SPAN-1:0] and_v, or_v, mixed, keep;
  logic [SPAN:0]   fits;

  for (genvar g = 0; g < LANES; g++) begin : g_off
    assign off[g] = fields[g*KW +: SPAN];
  end

  always_comb begin
    and_v = '1;
    or_v  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (sel_mask[i]) begin
        and_v = and_v & off[i];
        or_v  = or_v | off[i];
      end
    end
  end

  assign mixed = and_v ^ or_v;

  // Level g fits when no offset bit at or above g differs among the lanes.
  for (genvar g = 0; g <= SPAN; g++) begin : g_fit
    assign fits[g] = ((mixed >> g) == '0);
  end

  always_comb begin
    size_code = SZ_W'(SPAN);
    keep      = '0;
    for (int k = SPAN; k >= 0; k--) begin
      if (fits[k]) begin
        size_code = SZ_W'(k);
        keep      = SPAN'({SPAN{1'b1}} << k);
      end
    end
  end

  assign base = {blk, and_v & keep, {MIN_LG{1'b0}}};
endmodule

// File: rtl/coal_half_warp.sv
module coal_half_warp
  import coal_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int SEG_MIN_LG = 5,
  parameter int SEG_MAX_LG = 7,
  localparam int NLEV      = SEG_MAX_LG - SEG_MIN_LG + 1,
  localparam int SZ_W      = (NLEV > 1) ? $clog2(NLEV) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES-1:0]         in_lane_valid,
  input  logic [LANES*ADDR_W-1:0]  in_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ADDR_W-1:0]        out_base,
  output logic [SZ_W-1:0]          out_size,
  output logic [LANES-1:0]         out_mask,
  output logic                     batch_done
);
  localparam int KW   = ADDR_W - SEG_MIN_LG;
  localparam int SPAN = SEG_MAX_LG - SEG_MIN_LG;
  localparam int BW   = KW - SPAN;

  logic rst_sync_n;

  coal_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Only the bits at and above the smallest segment size are kept.
  logic [LANES*KW-1:0]         fields_d, fields_q;
  logic [LANES*SEG_MIN_LG-1:0] low_bits;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign fields_d[g*KW +: KW]               = in_addr[g*ADDR_W+SEG_MIN_LG +: KW];
    assign low_bits[g*SEG_MIN_LG +: SEG_MIN_LG] = in_addr[g*ADDR_W +: SEG_MIN_LG];
  end

  logic unused_low_bits;
  assign unused_low_bits = ^low_bits;

  coal_state_e      state_q, state_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic             done_q, done_d;
  logic             fields_en;
  logic             in_fire, out_fire;

  logic [BW-1:0]    best_blk;
  logic [LANES-1:0] sel_mask;

  coal_min_select #(
    .LANES (LANES),
    .KW    (KW),
    .SPAN  (SPAN)
  ) u_sel (
    .pend     (pend_q),
    .fields   (fields_q),
    .best_blk (best_blk),
    .sel_mask (sel_mask)
  );

  coal_trim #(
    .LANES  (LANES),
    .KW     (KW),
    .SPAN   (SPAN),
    .MIN_LG (SEG_MIN_LG),
    .SZ_W   (SZ_W)
  ) u_trim (
    .sel_mask  (sel_mask),
    .fields    (fields_q),
    .blk       (best_blk),
    .base      (out_base),
    .size_code (out_size)
  );

  assign in_ready   = (state_q == ST_IDLE) && rst_sync_n;
  assign out_valid  = (state_q == ST_ISSUE);
  assign out_mask   = sel_mask;
  assign batch_done = done_q;
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    done_d    = 1'b0;
    fields_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_fire) begin
          fields_en = 1'b1;
          pend_d    = in_lane_valid;
          if (|in_lane_valid) state_d = ST_ISSUE;
          else                done_d  = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (out_fire) begin
          pend_d = pend_q & ~sel_mask;
          if (pend_d == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fields_en) fields_q <= fields_d;
  end
endmodule

// File: rtl/coal_half_warp_chk.sv
module coal_half_warp_chk #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int SEG_MIN_LG = 5,
  parameter int NLEV       = 3,
  parameter int SZ_W       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANES-1:0]  in_lane_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_base,
  input logic [SZ_W-1:0]   out_size,
  input logic [LANES-1:0]  out_mask,
  input logic              batch_done
);
  logic [LANES-1:0]  live_q;
  logic [ADDR_W-1:0] prev_base_q;
  logic              have_prev_q;
  logic [ADDR_W-1:0] seg_low;

  assign seg_low = (ADDR_W'(1) << (SEG_MIN_LG + int'(out_size))) - ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q      <= '0;
      prev_base_q <= '0;
      have_prev_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      live_q      <= in_lane_valid;
      have_prev_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      live_q      <= live_q & ~out_mask;
      prev_base_q <= out_base;
      have_prev_q <= 1'b1;
    end
  end

  p_base_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_base & seg_low) == '0));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_size) <= NLEV - 1));

  p_mask_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0 && (out_mask & ~live_q) == '0));

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_prev_q) |-> (out_base > prev_base_q));

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> (!out_valid && in_ready));

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_base) &&
                                   $stable(out_size) && $stable(out_mask)));
endmodule

bind coal_half_warp coal_half_warp_chk #(
  .LANES      (LANES),
  .ADDR_W     (ADDR_W),
  .SEG_MIN_LG (SEG_MIN_LG),
  .NLEV       (NLEV),
  .SZ_W       (SZ_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_lane_valid (in_lane_valid),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_base      (out_base),
  .out_size      (out_size),
  .out_mask      (out_mask),
  .batch_done    (batch_done)
);

// File: tb/tb_coal_half_warp.sv
module tb_coal_half_warp;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int ADDR_W     = 32;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    in_valid;
  logic                    in_ready;
  logic [LANES-1:0]        in_lane_valid;
  logic [LANES*ADDR_W-1:0] in_addr;
  logic                    out_valid;
  logic                    out_ready;
  logic [ADDR_W-1:0]       out_base;
  logic [1:0]              out_size;
  logic [LANES-1:0]        out_mask;
  logic                    batch_done;

  coal_half_warp dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_lane_valid (in_lane_valid),
    .in_addr       (in_addr),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_base      (out_base),
    .out_size      (out_size),
    .out_mask      (out_mask),
    .batch_done    (batch_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] base;
    int          code;
    logic [15:0] mask;
  } txn_t;

  txn_t        expq[$];
  logic [31:0] lane_a [LANES];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural model: lowest 128-byte block first, smallest aligned fit.
  task automatic build(input logic [15:0] vm);
    logic [15:0] pend;
    pend = vm;
    expq.delete();
    while (pend != 0) begin
      int unsigned best;
      bit          found;
      txn_t        t;
      found = 0;
      best  = 0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && (!found || (lane_a[i] >> 7) < best)) begin
          best  = lane_a[i] >> 7;
          found = 1;
        end
      t.mask = '0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && (lane_a[i] >> 7) == best) t.mask[i] = 1'b1;
      t.code = -1;
      for (int lg = 5; lg <= 7; lg++) begin
        if (t.code < 0) begin
          bit          same;
          int unsigned ref_v;
          bit          have;
          same = 1; have = 0; ref_v = 0;
          for (int i = 0; i < LANES; i++)
            if (t.mask[i]) begin
              if (!have) begin ref_v = lane_a[i] >> lg; have = 1; end
              else if ((lane_a[i] >> lg) != ref_v) same = 0;
            end
          if (same) begin
            t.code = lg - 5;
            t.base = ref_v << lg;
          end
        end
      end
      expq.push_back(t);
      pend = pend & ~t.mask;
    end
  endtask

  task automatic run_batch(input logic [15:0] vm, input string req,
                           input int stall_pct, input int exp_n);
    int n;
    int cyc;
    build(vm);
    @(negedge clk);
    chk(in_ready == 1'b1, req, "in_ready before batch", in_ready, 1);
    for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = lane_a[i];
    in_lane_valid = vm;
    in_valid      = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    n   = 0;
    cyc = 0;
    forever begin
      bit fire;
      @(negedge clk);
      cyc++;
      if (cyc > 2000) begin
        chk(1'b0, req, "batch never finished", cyc, 0);
        break;
      end
      if (expq.size() == 0) begin
        chk(batch_done == 1'b1, "R10/R11", "batch_done at end", batch_done, 1);
        chk(out_valid == 1'b0, "R11", "out_valid after end", out_valid, 0);
        break;
      end
      chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
      chk(in_ready == 1'b0, "R11", "in_ready while busy", in_ready, 0);
      chk(batch_done == 1'b0, "R11", "batch_done while busy", batch_done, 0);
      chk(out_base == expq[0].base, {req, " R2/R6"}, "base", out_base, expq[0].base);
      chk(int'(out_size) == expq[0].code, {req, " R3/R4"}, "size code", out_size, expq[0].code);
      chk(out_mask == expq[0].mask, {req, " R5/R9"}, "lane mask", out_mask, expq[0].mask);
      out_ready = ($urandom_range(99) >= stall_pct);
      fire = out_valid && out_ready;
      @(posedge clk);
      if (fire) begin
        void'(expq.pop_front());
        n++;
      end
      #1 out_ready = 1'b0;
    end
    if (exp_n >= 0) chk(n == exp_n, req, "transaction count", n, exp_n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n         = 1'b0;
    in_valid      = 1'b0;
    out_ready     = 1'b0;
    in_lane_valid = '0;
    in_addr       = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(batch_done == 1'b0, "R1", "batch_done after reset", batch_done, 0);

    // R4 R7: sixteen consecutive words fill one 64-byte segment
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h1000 + i*4;
    run_batch(16'hFFFF, "R7", 40, 1);

    // R7: permuted, unaligned pattern inside one 128-byte block
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h2020 + ((i*7) % 16)*4;
    run_batch(16'hFFFF, "R7", 40, 1);

    // R8: stride two words
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h3000 + i*8;
    run_batch(16'hFFFF, "R8", 0, 1);

    // R8: stride three words
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h4000 + i*12;
    run_batch(16'hFFFF, "R8", 30, 2);

    // R13 R6: sixteen blocks in descending lane order
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h10000 - i*32'h100;
    run_batch(16'hFFFF, "R13", 30, 16);

    // R10: empty batch
    run_batch(16'h0000, "R10", 0, 0);

    // R5: disabled lanes point far away and must have no effect
    for (int i = 0; i < LANES; i++)
      lane_a[i] = (i % 2 == 1) ? 32'hFFFF0000 + i*4 : 32'h5000 + i*4;
    run_batch(16'h5555, "R5", 20, 1);

    // R4: every lane on the same word gives a 32-byte segment
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h6044;
    run_batch(16'hFFFF, "R4", 0, 1);

    // R12: long stalls on a multi-transaction batch
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h7000 + i*40;
    run_batch(16'hFFFF, "R12", 80, -1);

    // R9: random batches with partial masks and back-pressure
    for (int b = 0; b < 60; b++) begin
      for (int i = 0; i < LANES; i++) lane_a[i] = 32'h8000 + $urandom_range(511)*4;
      run_batch(16'($urandom), "R9", 35, -1);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule